// File: doc/BRIEF.md
# Configurable Programmable I/O Cell

This block is a behavioural, synthesizable model of a single user I/O cell in a programmable logic array. A static configuration word chooses how the cell behaves. On the inbound side, the resolved pad value goes straight to the fabric. The same value also feeds a storage element that works either as an edge flip-flop or as a level latch. On the outbound side, the pad driver takes its data either directly from the fabric or from a register. That data may be inverted, and a three-state control sets when the driver is active.

The cell sits on two shared clock lines, and each line has its own polarity bit. One polarity bit sets opposite senses for the two kinds of storage element on that line: the edge on which flip-flops capture, and the level at which latches are transparent. The configuration is loaded while a configuration-done input is low. It is frozen once that input rises. The pad is modelled as split ports: the cell's own driver value and enable, an external driver value and enable, and a resolved pad value. The resolved value includes the weak pull-up. Slew control is only stored and presented on an output.

Top module: `pio_cell`

## Requirements
- R1: While cfg_done is 0 the configuration word is taken from cfg_word; while cfg_done is 1 later changes on cfg_word have no effect. Bit layout: 0 in_latch, 1 in_line (0 = line A, 1 = line B), 2 out_reg, 3 out_inv, 4 out_line, 6:5 oe_mode, 7 t_is_en, 8 pull_off, 9 slew_fast, 10 line A invert, 11 line B invert. Both storage elements are held at 0 while cfg_done is 0.
- R2: With in_latch = 0 the input storage captures the resolved pad value on each rising edge of its selected effective clock line, and holds it otherwise.
- R3: With in_latch = 1 the input storage is transparent while its selected effective clock line is Low, and holds the last value while it is High.
- R4: The effective clock line equals the raw line XOR that line's invert bit. With the bit set, flip-flops capture on the falling raw edge and latches are transparent while the raw line is High.
- R5: pad_rd is resolved as follows. If pad_oe is 1, pad_rd equals pad_o. Otherwise, if pad_ext_en is 1, it equals pad_ext_val. Otherwise it equals 1 with the pull-up on, and 0 with the pull-up off. i_net always equals pad_rd, and q_net always shows the stored value.
- R6: With out_reg = 0 the driver data comes from o_net directly. With out_reg = 1 it comes from a register that captures o_net on each rising edge of the effective out_line clock.
- R7: With out_inv = 1 the driver data pad_o is the logical inverse of the selected source.
- R8: oe_mode 00 keeps pad_oe at 1. Modes 01 and 11 keep it at 0. Mode 10 derives it from t_net.
- R9: In mode 10 with t_is_en = 0, t_net = 1 disables the driver and t_net = 0 enables it. With t_is_en = 1 the sense is reversed.
- R10: With pull_off = 0 (the reset default of the word), an undriven pad reads 1. With pull_off = 1 it reads 0.
- R11: In mode 10 with t_is_en = 0, direct and non-inverted data, and t_net tied to o_net, the pad is driven Low when o_net is 0 and released otherwise.
- R12: rst_n = 0 clears both the input storage and the output register at once, whatever the clock lines are doing.
- R13: slew_fast presents the stored slew bit and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-Low chip reset, clears storage |
| cfg_done | input | 1 | 0 = configuration in progress, 1 = configured |
| cfg_word | input | 12 | Configuration word, taken while cfg_done is 0 |
| clk_line_a | input | 1 | Raw clock line A |
| clk_line_b | input | 1 | Raw clock line B |
| o_net | input | 1 | Output data from the fabric |
| t_net | input | 1 | Three-state control net from the fabric |
| pad_ext_en | input | 1 | External driver on the pad is active |
| pad_ext_val | input | 1 | Value of the external driver |
| pad_o | output | 1 | Data the cell's driver puts on the pad |
| pad_oe | output | 1 | Cell driver enable |
| pad_rd | output | 1 | Resolved pad value |
| i_net | output | 1 | Direct input value to the fabric |
| q_net | output | 1 | Stored input value to the fabric |
| slew_fast | output | 1 | Stored slew configuration bit |

## Verification
The clocked assertions sample data, the three-state net and the pad at the edges of the effective clock lines. They assume that no data input changes in the same instant as a clock line edge, and that the configuration moves only while cfg_done is low. The stimulus keeps to this: each step changes either the data inputs or exactly one raw clock line, never both. Polarity and line-select bits are rewritten only in steps where cfg_done is low. The bench also avoids contention between the external driver and the cell wherever an exact pad value is expected; the cell's own driver wins when both are active.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int NUM_LINES  = 2;
  localparam int LINE_SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

  typedef enum logic [1:0] {
    OE_ALWAYS = 2'b00,
    OE_NEVER  = 2'b01,
    OE_BY_T   = 2'b10,
    OE_SPARE  = 2'b11
  } oe_mode_e;

  // Field order is LSB last; bit positions are part of the contract.
  typedef struct packed {
    logic [NUM_LINES-1:0]  line_inv;
    logic                  slew_fast;
    logic                  pull_off;
    logic                  t_is_en;
    oe_mode_e              oe_mode;
    logic [LINE_SEL_W-1:0] out_line;
    logic                  out_inv;
    logic                  out_reg;
    logic [LINE_SEL_W-1:0] in_line;
    logic                  in_latch;
  } pio_cfg_t;

  localparam int CFG_W = $bits(pio_cfg_t);

  // Effective clock seen by every element on a line.
  function automatic logic eff_line(input logic raw, input logic inv);
    return raw ^ inv;
  endfunction

  // Driver enable from mode and control net.
  function automatic logic drive_enable(input oe_mode_e mode, input logic t,
                                        input logic t_is_en);
    logic en;
    case (mode)
      OE_ALWAYS: en = 1'b1;
      OE_BY_T:   en = t_is_en ? t : ~t;
      default:   en = 1'b0;
    endcase
    return en;
  endfunction

  // Pad value seen by the input path.
  function automatic logic resolve_pad(input logic oe, input logic drv,
                                       input logic ext_en, input logic ext_val,
                                       input logic pull_on);
    logic v;
    if (oe)          v = drv;
    else if (ext_en) v = ext_val;
    else             v = pull_on;
    return v;
  endfunction

endpackage

// File: rtl/pio_cfg_hold.sv
module pio_cfg_hold
  import pio_pkg::*;
(
  input  logic             rst_n,
  input  logic             cfg_done,
  input  logic [CFG_W-1:0] cfg_word,
  output pio_cfg_t         cfg_q,
  output logic             clr_n
);

  pio_cfg_t shadow;

  // Transparent while configuring, frozen afterwards.
  always_latch begin
    if (!cfg_done) shadow <= pio_cfg_t'(cfg_word);
  end

  assign cfg_q = shadow;
  assign clr_n = rst_n & cfg_done;

endmodule

// File: rtl/pio_clk_lines.sv
module pio_clk_lines
  import pio_pkg::*;
(
  input  logic [NUM_LINES-1:0]  line_raw,
  input  logic [NUM_LINES-1:0]  line_inv,
  input  logic [LINE_SEL_W-1:0] in_sel,
  input  logic [LINE_SEL_W-1:0] out_sel,
  output logic                  in_clk,
  output logic                  out_clk
);

  logic [NUM_LINES-1:0] line_eff;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign line_eff[g] = eff_line(line_raw[g], line_inv[g]);
  end

  assign in_clk  = line_eff[in_sel];
  assign out_clk = line_eff[out_sel];

endmodule

// File: rtl/pio_in_store.sv
module pio_in_store (
  input  logic clk_eff,
  input  logic clr_n,
  input  logic latch_mode,
  input  logic d,
  output logic q
);

  logic ff_q;
  logic lat_q;
  logic armed;

  always_ff @(posedge clk_eff or negedge clr_n) begin
    if (!clr_n) ff_q <= 1'b0;
    else        ff_q <= d;
  end

  // Transparent while the effective line is Low.
  always_latch begin
    if (!clr_n)        lat_q <= 1'b0;
    else if (!clk_eff) lat_q <= d;
  end

  always_ff @(posedge clk_eff or negedge clr_n) begin
    if (!clr_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign q = latch_mode ? lat_q : ff_q;

  // R2
  ff_capture_chk: assert property (@(posedge clk_eff) disable iff (!clr_n)
    armed |-> (ff_q == $past(d)));

  // R3
  latch_follow_chk: assert property (@(posedge clk_eff) disable iff (!clr_n)
    lat_q == d);

  // R12
  in_clear_chk: assert property (@(posedge clk_eff)
    !clr_n |-> (ff_q == 1'b0 && lat_q == 1'b0));

endmodule

// File: rtl/pio_out_path.sv
module pio_out_path (
  input  logic clk_eff,
  input  logic clr_n,
  input  logic o_net,
  input  logic reg_mode,
  input  logic invert,
  output logic drv
);

  logic oreg_q;
  logic armed;
  logic src;

  always_ff @(posedge clk_eff or negedge clr_n) begin
    if (!clr_n) oreg_q <= 1'b0;
    else        oreg_q <= o_net;
  end

  always_ff @(posedge clk_eff or negedge clr_n) begin
    if (!clr_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign src = reg_mode ? oreg_q : o_net;
  assign drv = src ^ invert;

  // R6
  oreg_capture_chk: assert property (@(posedge clk_eff) disable iff (!clr_n)
    armed |-> (oreg_q == $past(o_net)));

  // R12
  oreg_clear_chk: assert property (@(posedge clk_eff)
    !clr_n |-> (oreg_q == 1'b0));

endmodule

// File: rtl/pio_oe_ctrl.sv
module pio_oe_ctrl
  import pio_pkg::*;
(
  input  oe_mode_e mode,
  input  logic     t_net,
  input  logic     t_is_en,
  output logic     oe
);

  assign oe = drive_enable(mode, t_net, t_is_en);

endmodule

// File: rtl/pio_cell.sv
module pio_cell
  import pio_pkg::*;
(
  input  logic             rst_n,
  input  logic             cfg_done,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             clk_line_a,
  input  logic             clk_line_b,
  input  logic             o_net,
  input  logic             t_net,
  input  logic             pad_ext_en,
  input  logic             pad_ext_val,
  output logic             pad_o,
  output logic             pad_oe,
  output logic             pad_rd,
  output logic             i_net,
  output logic             q_net,
  output logic             slew_fast
);

  pio_cfg_t cfg;
  logic     clr_n;
  logic     in_clk;
  logic     out_clk;

  pio_cfg_hold u_cfg (
    .rst_n    (rst_n),
    .cfg_done (cfg_done),
    .cfg_word (cfg_word),
    .cfg_q    (cfg),
    .clr_n    (clr_n)
  );

  pio_clk_lines u_lines (
    .line_raw ({clk_line_b, clk_line_a}),
    .line_inv (cfg.line_inv),
    .in_sel   (cfg.in_line),
    .out_sel  (cfg.out_line),
    .in_clk   (in_clk),
    .out_clk  (out_clk)
  );

  pio_out_path u_out (
    .clk_eff  (out_clk),
    .clr_n    (clr_n),
    .o_net    (o_net),
    .reg_mode (cfg.out_reg),
    .invert   (cfg.out_inv),
    .drv      (pad_o)
  );

  pio_oe_ctrl u_oe (
    .mode    (cfg.oe_mode),
    .t_net   (t_net),
    .t_is_en (cfg.t_is_en),
    .oe      (pad_oe)
  );

  assign pad_rd = resolve_pad(pad_oe, pad_o, pad_ext_en, pad_ext_val, ~cfg.pull_off);
  assign i_net  = pad_rd;

  pio_in_store u_in (
    .clk_eff    (in_clk),
    .clr_n      (clr_n),
    .latch_mode (cfg.in_latch),
    .d          (pad_rd),
    .q          (q_net)
  );

  assign slew_fast = cfg.slew_fast;

  // R8
  oe_always_chk: assert property (@(posedge out_clk) disable iff (!clr_n)
    (cfg.oe_mode == OE_ALWAYS) |-> pad_oe);

  // R8
  oe_never_chk: assert property (@(posedge out_clk) disable iff (!clr_n)
    (cfg.oe_mode == OE_NEVER || cfg.oe_mode == OE_SPARE) |-> !pad_oe);

  // R11
  open_drain_chk: assert property (@(posedge out_clk) disable iff (!clr_n)
    (cfg.oe_mode == OE_BY_T && !cfg.t_is_en && !cfg.out_reg && !cfg.out_inv &&
     t_net == o_net) |-> ((pad_oe == !o_net) && (!pad_oe || !pad_rd)));

  // R10
  pull_up_chk: assert property (@(posedge out_clk) disable iff (!clr_n)
    (!pad_oe && !pad_ext_en && !cfg.pull_off) |-> pad_rd);

endmodule

// File: tb/pio_cell_test.sv
module pio_cell_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_done, la, lb, o_net, t_net, ee, ev;
  logic [11:0] cfg_in;
  logic [11:0] cfg_w;
  logic        d_pad_o, d_pad_oe, d_pad_rd, d_i, d_q, d_slew;

  pio_cell uut (
    .rst_n(rst_n), .cfg_done(cfg_done), .cfg_word(cfg_in),
    .clk_line_a(la), .clk_line_b(lb), .o_net(o_net), .t_net(t_net),
    .pad_ext_en(ee), .pad_ext_val(ev), .pad_o(d_pad_o), .pad_oe(d_pad_oe),
    .pad_rd(d_pad_rd), .i_net(d_i), .q_net(d_q), .slew_fast(d_slew)
  );

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  logic mq, mo, p_la, p_lb;

  // Open-drain vectors: {o, ext_en, ext_val, exp_oe, exp_rd}
  localparam logic [4:0] OD_VEC [8] = '{
    5'b00010, 5'b01110, 5'b10001, 5'b11000,
    5'b11101, 5'b00110, 5'b10101, 5'b01010
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b cfg=%h", req, what, act, exp, cfg_w);
    end
  endtask

  function automatic logic m_drv();
    return (cfg_w[2] ? mo : o_net) ^ cfg_w[3];
  endfunction

  function automatic logic m_oe();
    logic r;
    case (cfg_w[6:5])
      2'b00:   r = 1'b1;
      2'b10:   r = cfg_w[7] ? t_net : ~t_net;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  function automatic logic m_rd();
    if (m_oe()) return m_drv();
    if (ee) return ev;
    return ~cfg_w[8];
  endfunction

  // Updates the reference state after the caller changed inputs, then checks.
  task automatic tick();
    logic ein_o, ein_n, eo_o, eo_n, pad_b;
    ein_o = cfg_w[1] ? (p_lb ^ cfg_w[11]) : (p_la ^ cfg_w[10]);
    ein_n = cfg_w[1] ? (lb ^ cfg_w[11])   : (la ^ cfg_w[10]);
    eo_o  = cfg_w[4] ? (p_lb ^ cfg_w[11]) : (p_la ^ cfg_w[10]);
    eo_n  = cfg_w[4] ? (lb ^ cfg_w[11])   : (la ^ cfg_w[10]);
    if (!rst_n || !cfg_done) begin
      mq = 1'b0;
      mo = 1'b0;
    end else begin
      pad_b = m_rd();
      if (!cfg_w[0] && !ein_o && ein_n) mq = pad_b;
      if (!eo_o && eo_n) mo = o_net;
      if (cfg_w[0] && !ein_n) mq = m_rd();
    end
    p_la = la;
    p_lb = lb;
    @(posedge clk);
    chk("R8/R9", "pad_oe", d_pad_oe, m_oe());
    chk("R6/R7", "pad_o", d_pad_o, m_drv());
    chk("R5/R10", "pad_rd", d_pad_rd, m_rd());
    chk("R5", "i_net", d_i, m_rd());
    chk("R2/R3/R4", "q_net", d_q, mq);
    chk("R13", "slew_fast", d_slew, cfg_w[9]);
  endtask

  task automatic load_cfg(input logic [11:0] c);
    @(negedge clk);
    cfg_done = 1'b0; cfg_in = c; cfg_w = c;
    la = 1'b0; lb = 1'b0; o_net = 1'b0; t_net = 1'b0; ee = 1'b0; ev = 1'b0;
    tick();
    @(negedge clk);
    cfg_done = 1'b1;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_done = 1'b0; cfg_in = '0; cfg_w = '0;
    la = 1'b0; lb = 1'b0; o_net = 1'b0; t_net = 1'b0; ee = 1'b0; ev = 1'b0;
    mq = 1'b0; mo = 1'b0; p_la = 1'b0; p_lb = 1'b0;
    tick();
    // R12 reset state: storage clear, default word drives o_net, pull-up on
    chk("R12", "q_net at reset", d_q, 1'b0);
    chk("R10", "pull default word", cfg_w[8], 1'b0);
    @(negedge clk); rst_n = 1'b1; tick();

    // Sweep every combination of options
    for (int c = 0; c < 1536; c++) begin
      logic [11:0] w;
      logic [1:0]  md;
      md = 2'(c / 512);
      w = {c[6], c[5], c[0] ^ c[3], c[8], c[7], md, c[4], c[3], c[2], c[1], c[0]};
      load_cfg(w);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        o_net = k[0]; t_net = k[1]; ee = k[2]; ev = ~(k[0] ^ k[1]);
        tick();
        @(negedge clk);
        if (k % 2 == 0) la = ~la; else lb = ~lb;
        tick();
      end
    end

    // R11 open-drain table: T tied to O
    load_cfg(12'h040);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      o_net = OD_VEC[v][4]; t_net = OD_VEC[v][4]; ee = OD_VEC[v][3]; ev = OD_VEC[v][2];
      tick();
      chk("R11", "open-drain oe", d_pad_oe, OD_VEC[v][1]);
      chk("R11", "open-drain pad", d_pad_rd, OD_VEC[v][0]);
    end

    // R1 held: word changes after cfg_done have no effect
    load_cfg(12'h000);
    @(negedge clk); o_net = 1'b1; cfg_in = 12'h120; tick();
    chk("R1", "held oe", d_pad_oe, 1'b1);
    chk("R1", "held pad", d_pad_rd, 1'b1);
    chk("R1", "held slew", d_slew, 1'b0);

    // R10 pull-up off: undriven pad reads 0
    load_cfg(12'h120);
    chk("R10", "pull off pad", d_pad_rd, 1'b0);
    load_cfg(12'h020);
    chk("R10", "pull on pad", d_pad_rd, 1'b1);

    // R12 asynchronous reset clears both storage elements
    load_cfg(12'h024);
    @(negedge clk); o_net = 1'b1; ee = 1'b1; ev = 1'b1; tick();
    @(negedge clk); la = 1'b1; tick();
    chk("R2", "captured before reset", d_q, 1'b1);
    chk("R6", "registered before reset", d_pad_o, 1'b1);
    @(negedge clk); rst_n = 1'b0; tick();
    chk("R12", "q_net cleared", d_q, 1'b0);
    chk("R12", "out register cleared", d_pad_o, 1'b0);
    @(negedge clk); rst_n = 1'b1; tick();

    // R1 storage held clear during configuration
    @(negedge clk); cfg_done = 1'b0; cfg_in = 12'h001; cfg_w = 12'h001; la = 1'b0; tick();
    chk("R1", "q_net during config", d_q, 1'b0);

    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule